// File: doc/BRIEF.md
# Quadrature Encoder Position and Revolution Counter

This block turns the A, B and index (Z) signals of an incremental rotary encoder into a signed-free 16-bit position count and a separate 16-bit revolution count. Each of the three pins passes through a two-flop synchroniser. Each pin then has an edge qualifier that can be set to no edge, rising, falling or both. In quadrature mode every single transition of A or B moves the position by one step. The direction comes from which phase leads. In up/down mode, qualified A edges count up and qualified B edges count down.

The position wraps at a programmable maximum, and the revolution counter tracks each wrap. A qualified index edge clears the position and moves the revolution count in the last known direction. Two compare registers watch either counter and raise sticky flags. An interrupt line is the OR of the enabled flags. Software reaches everything through a plain write strobe and a read strobe. There are no streams, so there is no valid/ready handshake and no back-pressure. Every pin is plain control or status.

Top module: `qdx_encoder_counter`

## Requirements
- R1: After reset, both counters are 0, CTRL (addr 0) is 0 (stopped), POSMAX (addr 1) is 0xFFFF, both compare values are 0xFFFF, the flags are 0, the direction bit is 1 (up) and irq is 0.
- R2: When CTRL[1:0]=01 (quadrature), every transition of exactly one of A or B changes the position by one. The pin levels move through 00→10→11→01→00 (written as A,B) when A leads B, and that order counts up. The reverse order counts down. The change appears on pos_count three clock edges after the pin changes.
- R3: When CTRL[1:0]=10 (up/down), a qualified A edge adds one and a qualified B edge subtracts one. If both are qualified in the same cycle they cancel, and no flag is set.
- R4: The edge-select fields are A at CTRL[3:2], B at CTRL[5:4] and Z at CTRL[7:6]. The codes are 00 none, 01 rising, 10 falling and 11 both. An edge that its field does not select has no effect.
- R5: An up step taken while the position equals POSMAX sets the position to 0, adds one to the revolution count and sets flag bit 3.
- R6: A down step taken while the position is 0 sets the position to POSMAX, subtracts one from the revolution count and sets flag bit 4.
- R7: A qualified Z edge clears the position, sets flag bit 5 and changes the revolution count by +1 if the last step was up, or by -1 if it was down. If a count step comes in the same cycle, the index takes priority.
- R8: In quadrature mode, a change of both A and B in the same cycle leaves both counters unchanged and sets flag bit 2.
- R9: Compare 0 (value at addr 2) and compare 1 (value at addr 3) watch the position when CTRL[8] (or CTRL[9] for compare 1) is 0, and the revolution count when that bit is 1. Flag bit 0 (or bit 1) is set one cycle after the counters match, and stays set for as long as they match, even if software tries to clear it.
- R10: When CTRL[1:0]=00, pin activity changes neither counter.
- R11: A write to addr 4 loads the position, and a write to addr 5 loads the revolution count. Writing to addr 6 clears each flag whose data bit is 1. A read returns the register on rd_data one cycle after rd_en. Addr 6 reads back as {direction, flags[5:0]} in bits [6:0].
- R12: irq is high whenever any flag bit is set whose enable bit is set in addr 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_z | input | 1 | Encoder index (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, valid the cycle after rd_en |
| pos_count | output | 16 | Position counter |
| rev_count | output | 16 | Revolution counter |
| count_dir | output | 1 | Last step direction (1 = up) |
| irq | output | 1 | Interrupt, OR of the enabled flags |

## Verification
A pin change reaches the counters on the third rising edge after it occurs: two synchroniser flops, then the counter register. The flags follow on the next edge, and a read appears on rd_data one edge after the strobe. The bench changes pins on falling edges and waits five full cycles before it samples. Every sample is taken on a falling edge, so it never races a flop. Register writes and reads are one-cycle strobes placed between falling edges. Each read is checked on the falling edge that follows.

// File: rtl/qdx_pkg.sv
package qdx_pkg;
  localparam int CW = 16;
  localparam int AW = 3;

  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_QUAD = 2'b01,
    MODE_UPDN = 2'b10,
    MODE_HOLD = 2'b11
  } cnt_mode_e;

  localparam logic [AW-1:0] ADR_CTRL  = 3'd0;
  localparam logic [AW-1:0] ADR_PMAX  = 3'd1;
  localparam logic [AW-1:0] ADR_CMP0  = 3'd2;
  localparam logic [AW-1:0] ADR_CMP1  = 3'd3;
  localparam logic [AW-1:0] ADR_POS   = 3'd4;
  localparam logic [AW-1:0] ADR_REV   = 3'd5;
  localparam logic [AW-1:0] ADR_FLAGS = 3'd6;
  localparam logic [AW-1:0] ADR_IRQEN = 3'd7;

  localparam int NFLAG = 6;
  localparam int F_CMP0 = 0;
  localparam int F_CMP1 = 1;
  localparam int F_ERR  = 2;
  localparam int F_OVF  = 3;
  localparam int F_UNF  = 4;
  localparam int F_IDX  = 5;

  localparam int CTRL_W = 10;
endpackage

// File: rtl/qdx_edge_det.sv
module qdx_edge_det #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       lvl,
  output logic       chg,
  output logic       hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl  = sync_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
  assign chg  = rise | fall;
  assign hit  = (sel[0] & rise) | (sel[1] & fall);
endmodule

// File: rtl/qdx_step_gen.sv
module qdx_step_gen
  import qdx_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       a_lvl,
  input  logic       a_chg,
  input  logic       a_hit,
  input  logic       b_lvl,
  input  logic       b_chg,
  input  logic       b_hit,
  output logic       step_up,
  output logic       step_dn,
  output logic       err_evt
);
  logic b_old;
  logic lead_a;

  assign b_old  = b_lvl ^ b_chg;
  assign lead_a = a_lvl ^ b_old;

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    err_evt = 1'b0;
    unique case (cnt_mode_e'(mode))
      MODE_QUAD: begin
        if (a_chg && b_chg) begin
          err_evt = 1'b1;
        end else if (a_chg || b_chg) begin
          step_up = lead_a;
          step_dn = ~lead_a;
        end
      end
      MODE_UPDN: begin
        step_up = a_hit & ~b_hit;
        step_dn = b_hit & ~a_hit;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qdx_counter_core.sv
module qdx_counter_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_pos,
  input  logic         wr_rev,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] posmax,
  input  logic         step_up,
  input  logic         step_dn,
  input  logic         idx_evt,
  output logic [W-1:0] pos,
  output logic [W-1:0] rev,
  output logic         dir,
  output logic         ovf_evt,
  output logic         unf_evt
);
  localparam logic [W-1:0] ONE = W'(1);

  logic plain;
  assign plain   = ~wr_pos & ~idx_evt;
  assign ovf_evt = plain & step_up & (pos == posmax);
  assign unf_evt = plain & step_dn & (pos == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      rev <= '0;
      dir <= 1'b1;
    end else begin
      if (step_up) dir <= 1'b1;
      else if (step_dn) dir <= 1'b0;

      if (wr_pos)             pos <= load_val;
      else if (idx_evt)       pos <= '0;
      else if (ovf_evt)       pos <= '0;
      else if (unf_evt)       pos <= posmax;
      else if (step_up)       pos <= pos + ONE;
      else if (step_dn)       pos <= pos - ONE;

      if (wr_rev)             rev <= load_val;
      else if (idx_evt)       rev <= dir ? rev + ONE : rev - ONE;
      else if (ovf_evt)       rev <= rev + ONE;
      else if (unf_evt)       rev <= rev - ONE;
    end
  end
endmodule

// File: rtl/qdx_encoder_counter.sv
module qdx_encoder_counter
  import qdx_pkg::*;
#(
  parameter int W          = CW,
  parameter int SYNC_STAGE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enc_a,
  input  logic          enc_b,
  input  logic          enc_z,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  pos_count,
  output logic [W-1:0]  rev_count,
  output logic          count_dir,
  output logic          irq
);
  localparam int NCMP = 2;

  logic [CTRL_W-1:0] ctrl;
  logic [W-1:0]      posmax;
  logic [W-1:0]      cmp_val [NCMP];
  logic [NFLAG-1:0]  flags;
  logic [NFLAG-1:0]  irq_en;
  logic [1:0]        mode;
  logic              run;

  logic a_lvl, a_chg, a_hit;
  logic b_lvl, b_chg, b_hit;
  logic z_lvl, z_chg, z_hit;
  logic step_up, step_dn, err_evt, idx_evt;
  logic ovf_evt, unf_evt;
  logic wr_pos, wr_rev;
  logic [W-1:0] pos, rev;
  logic dir;
  logic [NCMP-1:0] cmp_eq;
  logic [NFLAG-1:0] flag_set, flag_clr;

  assign mode = ctrl[1:0];
  assign run  = (mode == MODE_QUAD) || (mode == MODE_UPDN);

  qdx_edge_det #(.STAGES(SYNC_STAGE)) u_ea (
    .clk(clk), .rst_n(rst_n), .pin(enc_a), .sel(ctrl[3:2]),
    .lvl(a_lvl), .chg(a_chg), .hit(a_hit));
  qdx_edge_det #(.STAGES(SYNC_STAGE)) u_eb (
    .clk(clk), .rst_n(rst_n), .pin(enc_b), .sel(ctrl[5:4]),
    .lvl(b_lvl), .chg(b_chg), .hit(b_hit));
  qdx_edge_det #(.STAGES(SYNC_STAGE)) u_ez (
    .clk(clk), .rst_n(rst_n), .pin(enc_z), .sel(ctrl[7:6]),
    .lvl(z_lvl), .chg(z_chg), .hit(z_hit));

  qdx_step_gen u_step (
    .mode(mode),
    .a_lvl(a_lvl), .a_chg(a_chg), .a_hit(a_hit),
    .b_lvl(b_lvl), .b_chg(b_chg), .b_hit(b_hit),
    .step_up(step_up), .step_dn(step_dn), .err_evt(err_evt));

  assign idx_evt = run & z_hit;
  assign wr_pos  = wr_en && (wr_addr == ADR_POS);
  assign wr_rev  = wr_en && (wr_addr == ADR_REV);

  qdx_counter_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .wr_pos(wr_pos), .wr_rev(wr_rev), .load_val(wr_data),
    .posmax(posmax), .step_up(step_up), .step_dn(step_dn),
    .idx_evt(idx_evt), .pos(pos), .rev(rev), .dir(dir),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt));

  for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
    logic use_rev;
    assign use_rev    = ctrl[8+gi];
    assign cmp_eq[gi] = (use_rev ? rev : pos) == cmp_val[gi];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cmp_val[gi] <= '1;
      else if (wr_en && (wr_addr == ADR_CMP0 + AW'(gi)))
        cmp_val[gi] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      posmax <= '1;
      irq_en <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL:  ctrl   <= wr_data[CTRL_W-1:0];
        ADR_PMAX:  posmax <= wr_data;
        ADR_IRQEN: irq_en <= wr_data[NFLAG-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    flag_set         = '0;
    flag_set[F_CMP0] = cmp_eq[0];
    flag_set[F_CMP1] = cmp_eq[1];
    flag_set[F_ERR]  = err_evt;
    flag_set[F_OVF]  = ovf_evt;
    flag_set[F_UNF]  = unf_evt;
    flag_set[F_IDX]  = idx_evt;
  end

  assign flag_clr = (wr_en && (wr_addr == ADR_FLAGS)) ? wr_data[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (rd_addr)
        ADR_CTRL:  rd_data <= W'(ctrl);
        ADR_PMAX:  rd_data <= posmax;
        ADR_CMP0:  rd_data <= cmp_val[0];
        ADR_CMP1:  rd_data <= cmp_val[1];
        ADR_POS:   rd_data <= pos;
        ADR_REV:   rd_data <= rev;
        ADR_FLAGS: rd_data <= W'({dir, flags});
        default:   rd_data <= W'(irq_en);
      endcase
    end
  end

  assign pos_count = pos;
  assign rev_count = rev;
  assign count_dir = dir;
  assign irq       = |(flags & irq_en);
endmodule

// File: rtl/qdx_encoder_counter_chk.sv
module qdx_encoder_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic [W-1:0] pos,
  input logic [W-1:0] rev,
  input logic [W-1:0] posmax,
  input logic         step_up,
  input logic         step_dn,
  input logic         err_evt,
  input logic         idx_evt,
  input logic         wr_pos,
  input logic         wr_rev,
  input logic [1:0]   cmp_eq,
  input logic [5:0]   flags
);
  a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn, err_evt}));

  a_r5_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    step_up && !idx_evt && !wr_pos && (pos == posmax) |=> pos == '0);

  a_r6_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn && !idx_evt && !wr_pos && (pos == '0) |=> pos == $past(posmax));

  a_r7_index_clear: assert property (@(posedge clk) disable iff (!rst_n)
    idx_evt && !wr_pos |=> pos == '0);

  a_r8_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt && !idx_evt && !wr_pos |=> pos == $past(pos));

  a_r10_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) && !wr_pos && !wr_rev |=> (pos == $past(pos)) && (rev == $past(rev)));

  a_r9_cmp0_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_eq[0] |=> flags[0]);

  a_r9_cmp1_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_eq[1] |=> flags[1]);
endmodule

bind qdx_encoder_counter qdx_encoder_counter_chk #(.W(W)) u_chk (.*);

// File: tb/tb_qdx_encoder_counter.sv
module tb_qdx_encoder_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_z = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data, pos_count, rev_count;
  logic        count_dir, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  qdx_encoder_counter dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pos_count(pos_count), .rev_count(rev_count),
    .count_dir(count_dir), .irq(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic pins(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    settle();
  endtask

  task automatic zpin(input logic z);
    @(negedge clk);
    enc_z = z;
    settle();
  endtask

  task automatic wreg(input logic [2:0] ad, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ad; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rreg(input logic [2:0] ad, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = ad;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 pos", pos_count, 16'h0000);
    chk("R1 rev", rev_count, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    rreg(3'd0, v); chk("R1 ctrl", v, 16'h0000);
    rreg(3'd1, v); chk("R1 posmax", v, 16'hFFFF);
    rreg(3'd2, v); chk("R1 cmp0", v, 16'hFFFF);
    rreg(3'd6, v); chk("R1 flags", v, 16'h0040);
  endtask

  task automatic t_stop_idle();
    pins(1'b1, 1'b0);
    chk("R10 stop a", pos_count, 16'h0000);
    pins(1'b0, 1'b0);
    chk("R10 stop rev", rev_count, 16'h0000);
  endtask

  task automatic t_quad_up();
    logic [15:0] v;
    wreg(3'd0, 16'h0001);
    pins(1'b1, 1'b0); chk("R2 up1", pos_count, 16'd1);
    pins(1'b1, 1'b1); chk("R2 up2", pos_count, 16'd2);
    pins(1'b0, 1'b1); chk("R2 up3", pos_count, 16'd3);
    pins(1'b0, 1'b0); chk("R2 up4", pos_count, 16'd4);
    rreg(3'd6, v); chk("R2 dir up", v, 16'h0040);
  endtask

  task automatic t_quad_latency();
    @(negedge clk); enc_b = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 not yet", pos_count, 16'd4);
    @(negedge clk);
    chk("R2 third edge", pos_count, 16'd3);
    settle();
    pins(1'b1, 1'b1); chk("R2 down", pos_count, 16'd2);
    chk("R2 dir pin", {15'd0, count_dir}, 16'h0000);
  endtask

  task automatic t_illegal();
    logic [15:0] v;
    pins(1'b0, 1'b0);
    chk("R8 hold", pos_count, 16'd2);
    rreg(3'd6, v); chk("R8 err flag", v, 16'h0004);
    wreg(3'd6, 16'h003F);
    rreg(3'd6, v); chk("R11 flag clear", v, 16'h0000);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    wreg(3'd1, 16'd5);
    wreg(3'd4, 16'd4);
    wreg(3'd5, 16'd0);
    chk("R11 pos load", pos_count, 16'd4);
    pins(1'b1, 1'b0); chk("R5 at max", pos_count, 16'd5);
    pins(1'b1, 1'b1);
    chk("R5 wrap pos", pos_count, 16'd0);
    chk("R5 wrap rev", rev_count, 16'd1);
    rreg(3'd6, v); chk("R5 ovf flag", v, 16'h0048);
    pins(1'b1, 1'b0);
    chk("R6 wrap pos", pos_count, 16'd5);
    chk("R6 wrap rev", rev_count, 16'd0);
    rreg(3'd6, v); chk("R6 unf flag", v, 16'h0018);
    wreg(3'd6, 16'h003F);
  endtask

  task automatic t_index();
    logic [15:0] v;
    wreg(3'd0, 16'h0041);
    zpin(1'b1);
    chk("R7 clear", pos_count, 16'd0);
    chk("R7 rev down", rev_count, 16'hFFFF);
    rreg(3'd6, v); chk("R7 idx flag", v, 16'h0020);
    pins(1'b1, 1'b1); chk("R7 step", pos_count, 16'd1);
    zpin(1'b0); chk("R4 z fall ignored", pos_count, 16'd1);
    zpin(1'b1);
    chk("R7 clear2", pos_count, 16'd0);
    chk("R7 rev up", rev_count, 16'h0000);
    wreg(3'd6, 16'h003F);
    wreg(3'd1, 16'hFFFF);
  endtask

  task automatic t_updown();
    logic [15:0] v;
    wreg(3'd0, 16'h0036);
    wreg(3'd4, 16'd10);
    pins(1'b0, 1'b1); chk("R4 a fall ignored", pos_count, 16'd10);
    pins(1'b1, 1'b1); chk("R3 a rise up", pos_count, 16'd11);
    pins(1'b1, 1'b0); chk("R3 b fall down", pos_count, 16'd10);
    pins(1'b1, 1'b1); chk("R3 b rise down", pos_count, 16'd9);
    pins(1'b0, 1'b1); chk("R4 a fall ignored2", pos_count, 16'd9);
    pins(1'b1, 1'b0); chk("R3 cancel", pos_count, 16'd9);
    rreg(3'd6, v); chk("R3 no flag", v, 16'h0000);
  endtask

  task automatic t_compare();
    logic [15:0] v;
    wreg(3'd0, 16'h0236);
    wreg(3'd2, 16'd12);
    wreg(3'd3, 16'd3);
    wreg(3'd5, 16'd3);
    pins(1'b0, 1'b0); pins(1'b1, 1'b0);
    pins(1'b0, 1'b0); pins(1'b1, 1'b0);
    pins(1'b0, 1'b0); pins(1'b1, 1'b0);
    chk("R9 pos reach", pos_count, 16'd12);
    rreg(3'd6, v); chk("R9 both flags", v, 16'h0043);
    wreg(3'd6, 16'h003F);
    rreg(3'd6, v); chk("R9 sticky while equal", v, 16'h0043);
    chk("R12 irq masked", {15'd0, irq}, 16'h0000);
    wreg(3'd7, 16'h0002);
    chk("R12 irq on", {15'd0, irq}, 16'h0001);
    wreg(3'd4, 16'd0);
    wreg(3'd5, 16'd0);
    wreg(3'd6, 16'h003F);
    rreg(3'd6, v); chk("R11 clear after move", v, 16'h0040);
    chk("R12 irq off", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_stop_mode();
    wreg(3'd0, 16'h0000);
    pins(1'b0, 1'b0); pins(1'b1, 1'b1);
    chk("R10 stop pos", pos_count, 16'd0);
    chk("R10 stop rev", rev_count, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stop_idle();
    t_quad_up();
    t_quad_latency();
    t_illegal();
    t_wrap();
    t_index();
    t_updown();
    t_compare();
    t_stop_mode();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule